// File: doc/BRIEF.md
# Slot power and reset sequencer

This block runs the power and reset sequences for one downstream slot. It drives a power-enable output and an active-low slot reset output. It watches an active-low power-good input from the slot supply. A control bit held by the surrounding register logic picks the target state. A value of 0 asks for the slot to be powered. A value of 1 asks for it to be shut down.

Two 8-bit delay fields set the spacing between the edges. The up delay is the gap between power becoming valid and reset being released. The down delay is the gap between reset being applied and power being removed. Both delays count pulses of a prescaled tick input, not clock cycles.

A mode input selects when the up delay starts. In the enable-timed mode it starts as soon as power enable rises. In the power-good-timed mode it waits for the supply to report good. The power-good-timed mode also watches for supply faults while the slot is running.

Top module: `slot_pwr_seq`

## Requirements
- R1: While `pwr_en` is 0, `slot_rst_n` is 0. With `ctl_off` held at 1 the block stays in this state indefinitely.
- R2: When the block is off and `ctl_off` is sampled at 0, `pwr_en` is 1 one clock later. When the block is on and `ctl_off` is sampled at 1, a power-down starts.
- R3: In the enable-timed mode (`mode_pg`=0), `slot_rst_n` rises on the clock edge of the (`up_dly`+1)-th tick that follows the rise of `pwr_en`. `pwr_en` is already 1 at that point.
- R4: A power-down drives `slot_rst_n` to 0 first, one clock after the request, while `pwr_en` stays 1. `pwr_en` then falls on the edge of the (`dn_dly`+1)-th tick after that.
- R5: In the power-good-timed mode (`mode_pg`=1), reset is never released while power good has not been observed. The (`up_dly`+1) ticks are counted only after `pgood_n`=0 has passed the two-flop synchronizer.
- R6: In the power-good-timed mode, when `pgood_n` goes to 1 while `slot_rst_n` is 1, `slot_rst_n` falls on the third clock edge after the change. This is two synchronizer stages plus one state update, with no tick delay.
- R7: After release, `slot_rst_n` stays 1 as long as `ctl_off` is 0 and no fault is seen.
- R8: The delays advance only on clock edges where `tick` is 1. A delay value of 0 completes on the first tick after the sequence starts.
- R9: Asserting the asynchronous `rst_n` low forces `pwr_en`=0 and `slot_rst_n`=0 at once, without waiting for a clock edge.
- R10: After a fault, `pwr_en` stays 1 and `slot_rst_n` stays 0, even if power good returns. This holds until `ctl_off`=1 runs a normal power-down. A later `ctl_off`=0 runs the full power-up again.
- R11: A change of `ctl_off` during a power-up or power-down does not abort it. The running sequence finishes, and the new request is then acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | Prescaled delay unit, one-cycle pulse |
| ctl_off | input | 1 | Power control bit: 0 requests power on, 1 requests power off |
| mode_pg | input | 1 | 0 = enable-timed release, 1 = power-good-timed release with fault detection |
| up_dly | input | 8 | Ticks minus one from power valid to reset release |
| dn_dly | input | 8 | Ticks minus one from reset assertion to power removal |
| pgood_n | input | 1 | Active-low supply good, asynchronous |
| pwr_en | output | 1 | Slot power enable |
| slot_rst_n | output | 1 | Active-low slot reset |

## Verification
The hardest situation to reach is the power-good-timed release. Its tick count has to be separated from the time spent waiting for the supply and from the synchronizer latency. The stimulus drops `pgood_n` on the falling edge just after a tick. With a four-cycle tick period, no tick lands during the synchronizer delay, so the count of ticks seen with power good asserted must equal `up_dly`+1 exactly. Fault entry is reached from a settled on state by raising `pgood_n`. Power good is then restored, which shows that the fault latch does not clear by itself. Mid-sequence control changes are made while a 21-tick delay is still running.

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ctl_off,
  input  logic          mode_pg,
  input  logic [DW-1:0] up_dly,
  input  logic [DW-1:0] dn_dly,
  input  logic          pgood_n,
  output logic          pwr_en,
  output logic          slot_rst_n
);

  typedef enum logic [2:0] {S_OFF, S_WAIT_PG, S_UP, S_ON, S_FAULT, S_DN} st_t;

  st_t            st;
  logic [DW-1:0]  cnt;
  logic [SYNC-1:0] pg_sh;
  logic           pg_bad;
  logic           up_done, dn_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pg_sh <= '1;
    else        pg_sh <= {pg_sh[SYNC-2:0], pgood_n};

  assign pg_bad  = pg_sh[SYNC-1];
  assign up_done = tick && (cnt == up_dly);
  assign dn_done = tick && (cnt == dn_dly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      unique case (st)
        S_OFF:
          if (!ctl_off) begin
            st  <= mode_pg ? S_WAIT_PG : S_UP;
            cnt <= '0;
          end
        S_WAIT_PG:
          if (!pg_bad) begin
            st  <= S_UP;
            cnt <= '0;
          end
        S_UP:
          if (mode_pg && pg_bad) st <= S_WAIT_PG;
          else if (up_done)      st <= S_ON;
          else if (tick)         cnt <= cnt + 1'b1;
        S_ON:
          if (ctl_off) begin
            st  <= S_DN;
            cnt <= '0;
          end else if (mode_pg && pg_bad) begin
            st <= S_FAULT;
          end
        S_FAULT:
          if (ctl_off) begin
            st  <= S_DN;
            cnt <= '0;
          end
        S_DN:
          if (dn_done)   st <= S_OFF;
          else if (tick) cnt <= cnt + 1'b1;
        default: st <= S_OFF;
      endcase
    end
  end

  assign pwr_en     = (st != S_OFF);
  assign slot_rst_n = (st == S_ON);

endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic mode_pg,
  input logic pg_bad,
  input logic pwr_en,
  input logic slot_rst_n
);

  p_off_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !slot_rst_n);

  p_up_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_rst_n) |-> $past(pwr_en));

  p_dn_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(!slot_rst_n));

  p_pg_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(slot_rst_n) && $past(mode_pg)) |-> $past(!pg_bad));

  p_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_rst_n && mode_pg && pg_bad) |=> !slot_rst_n);

  p_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(slot_rst_n) || $fell(pwr_en)) |-> $past(tick));

endmodule

bind slot_pwr_seq slot_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode_pg(mode_pg),
  .pg_bad(pg_bad), .pwr_en(pwr_en), .slot_rst_n(slot_rst_n)
);

// File: tb/test_slot_pwr_seq.sv
module test_slot_pwr_seq;
  logic clk = 0, rst_n = 0, tick = 0, ctl_off = 1, mode_pg = 0, pgood_n = 1;
  logic [7:0] up_dly = 0, dn_dly = 0;
  logic pwr_en, slot_rst_n;
  logic tick_en = 1;
  int tdiv = 0, checks = 0, errors = 0, tcnt_up = 0, tcnt_dn = 0;
  logic tk_e = 0, pg_e = 1, ctl_e = 1, pe_p = 0, rn_p = 0;

  slot_pwr_seq i_slot_pwr_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_off(ctl_off), .mode_pg(mode_pg),
    .up_dly(up_dly), .dn_dly(dn_dly), .pgood_n(pgood_n),
    .pwr_en(pwr_en), .slot_rst_n(slot_rst_n)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!tick_en) begin tick = 0; tdiv = 0; end
    else begin tdiv = (tdiv + 1) % 4; tick = (tdiv == 0); end
  end

  always @(posedge clk) begin tk_e = tick; pg_e = pgood_n; ctl_e = ctl_off; end

  always @(negedge clk) begin
    if (tk_e && pe_p && !rn_p) begin
      if (ctl_e) tcnt_dn++;
      else if (!mode_pg || !pg_e) tcnt_up++;
    end
    pe_p = pwr_en; rn_p = slot_rst_n;
  end

  function automatic int exp_ticks(input logic [7:0] d);
    return int'(d) + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rn(input logic v, input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (slot_rst_n === v) begin ok = 1; break; end
    end
    #1;
  endtask

  task automatic wait_pe(input logic v, input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (pwr_en === v) begin ok = 1; break; end
    end
    #1;
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    check(pwr_en === 0 && slot_rst_n === 0, "R9 reset state", {pwr_en, slot_rst_n}, 0);
    rst_n = 1;
    repeat (40) @(negedge clk);
    check(pwr_en === 0 && slot_rst_n === 0, "R1 stays off", {pwr_en, slot_rst_n}, 0);

    for (int it = 0; it < 6; it++) begin
      mode_pg = 0;
      up_dly = (it == 0) ? 8'd0 : (it == 1) ? 8'd255 : 8'($urandom % 20);
      dn_dly = (it == 0) ? 8'd0 : (it == 1) ? 8'd255 : 8'($urandom % 20);
      tcnt_up = 0;
      ctl_off = 0;
      @(negedge clk);
      check(pwr_en === 1 && slot_rst_n === 0, "R2 power up start", {pwr_en, slot_rst_n}, 2);
      wait_rn(1, 5000, ok);
      check(ok && pwr_en === 1, "R3 reset released", ok, 1);
      check(tcnt_up == exp_ticks(up_dly), "R3 R8 up ticks", tcnt_up, exp_ticks(up_dly));
      repeat (30) @(negedge clk);
      check(slot_rst_n === 1, "R7 held released", slot_rst_n, 1);
      tcnt_dn = 0;
      ctl_off = 1;
      @(negedge clk);
      check(slot_rst_n === 0 && pwr_en === 1, "R4 reset first", {pwr_en, slot_rst_n}, 2);
      wait_pe(0, 5000, ok);
      check(ok && tcnt_dn == exp_ticks(dn_dly), "R4 R8 down ticks", tcnt_dn, exp_ticks(dn_dly));
    end

    mode_pg = 1; pgood_n = 1;
    up_dly = 8'($urandom % 20); dn_dly = 8'd2;
    tcnt_up = 0;
    ctl_off = 0;
    repeat (160) @(negedge clk);
    check(pwr_en === 1 && slot_rst_n === 0, "R5 no release without power good", {pwr_en, slot_rst_n}, 2);
    @(posedge clk iff tick);
    @(negedge clk);
    pgood_n = 0;
    wait_rn(1, 5000, ok);
    check(ok && tcnt_up == exp_ticks(up_dly), "R5 ticks after power good", tcnt_up, exp_ticks(up_dly));

    repeat (7) @(negedge clk);
    pgood_n = 1;
    @(negedge clk);
    @(negedge clk);
    check(slot_rst_n === 1, "R6 sync latency", slot_rst_n, 1);
    @(negedge clk);
    check(slot_rst_n === 0 && pwr_en === 1, "R6 R10 fault reset", {pwr_en, slot_rst_n}, 2);
    pgood_n = 0;
    repeat (50) @(negedge clk);
    check(slot_rst_n === 0 && pwr_en === 1, "R10 fault held", {pwr_en, slot_rst_n}, 2);
    ctl_off = 1;
    wait_pe(0, 2000, ok);
    check(ok && slot_rst_n === 0, "R10 power down after fault", ok, 1);
    ctl_off = 0;
    wait_rn(1, 5000, ok);
    check(ok && pwr_en === 1, "R10 rerun power up", ok, 1);
    ctl_off = 1;
    wait_pe(0, 2000, ok);

    mode_pg = 0; up_dly = 8'd20; dn_dly = 8'd20;
    ctl_off = 0;
    repeat (10) @(negedge clk);
    ctl_off = 1;
    wait_rn(1, 2000, ok);
    check(ok, "R11 up finishes despite off request", ok, 1);
    wait_pe(0, 2000, ok);
    check(ok, "R11 deferred power down", ok, 1);
    ctl_off = 0;
    wait_rn(1, 2000, ok);
    ctl_off = 1;
    repeat (10) @(negedge clk);
    ctl_off = 0;
    wait_pe(0, 2000, ok);
    check(ok, "R11 down finishes despite on request", ok, 1);
    wait_pe(1, 20, ok);
    check(ok, "R11 deferred power up", ok, 1);
    wait_rn(1, 2000, ok);

    #3 rst_n = 0;
    #1 check(pwr_en === 0 && slot_rst_n === 0, "R9 async reset", {pwr_en, slot_rst_n}, 0);
    #20 rst_n = 1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule